// File: doc/BRIEF.md
# External Bus Write Cycle Sequencer

This block turns single write requests from an internal port into write cycles on an external asynchronous parallel memory bus. Each cycle has three phases. A lead phase drives chip-select, the direction line and the address. An active phase pulses write-enable while data is driven. A trail phase holds the data and direction after chip-select has been released. Each phase length is programmed in cycles of the timing clock. An optional asynchronous ready input can stretch the active phase. That input is brought into the clock domain through a flip-flop synchronizer and is tested on a fixed schedule set by the active length.

The block also produces the bus output clock, either at the timing-clock rate or at half of it. In half-rate mode every access must begin on a rising edge of that output clock. When a request arrives at the wrong phase, one alignment cycle is inserted first. The requester raises `req` with address and data. It holds them until `ack` pulses for one cycle at the end of the trail phase, then lowers `req`. Configuration inputs are changed only while the bus is idle.

Top module: `xbus_wr_seq`

## Requirements
- R1: An accepted request produces, in order, a lead phase of `cfg_lead` cycles, an active phase of `cfg_active` cycles and a trail phase of `cfg_trail` cycles, all counted in timing-clock cycles, with `ack` high only in the final trail cycle.
- R2: A programmed length of zero for lead, active or trail is treated as one cycle.
- R3: With `cfg_half_clk` = 1 the bus clock toggles on every timing-clock edge and the first lead cycle always has the bus clock high. If a request is sampled while the bus clock is high, exactly one alignment cycle precedes the lead phase, otherwise none. With `cfg_half_clk` = 0 no alignment cycle is ever inserted.
- R4: In reset, idle and alignment cycles `bus_cs_n`, `bus_we_n` and `bus_rnw` are 1 and `bus_doe` is 0.
- R5: `bus_addr` takes the request address at the first lead cycle and keeps that value through the later idle and alignment cycles until the next lead phase.
- R6: `bus_cs_n` is 0 in lead and active cycles only. `bus_we_n` is 0 in active cycles only. `bus_rnw` is 0 in lead, active and trail cycles. `bus_doe` is 1 with `bus_dout` equal to the request data in active and trail cycles only.
- R7: With `cfg_use_rdy` = 1 the active phase lasts at least 3 cycles. Counting active cycles from 0, the phase may end after cycle j (j ≥ length−1) only if `bus_rdy_async` was high at the clock edge that starts cycle j−1. A rise of ready in the middle of cycle r therefore gives an active length of max(length, r+3).
- R8: With `cfg_use_rdy` = 0 the level of `bus_rdy_async` has no effect on any phase length.
- R9: `ack` is never high for two consecutive cycles, and one request held high until `ack` yields exactly one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_half_clk | input | 1 | 1: bus clock at half the timing rate |
| cfg_lead | input | 4 | Lead phase length in timing cycles |
| cfg_active | input | 4 | Active phase length in timing cycles |
| cfg_trail | input | 4 | Trail phase length in timing cycles |
| cfg_use_rdy | input | 1 | 1: stretch active phase with ready input |
| req | input | 1 | Write request, held until ack |
| req_addr | input | 19 | Write address |
| req_data | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| bus_rdy_async | input | 1 | Asynchronous ready from the external device |
| bus_clk_out | output | 1 | Bus output clock |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_rnw | output | 1 | Direction, 0 during a write cycle |
| bus_addr | output | 19 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | Data output enable for the pad drivers |

## Verification
The bench builds the block with its default parameters: a 19-bit address, 16-bit data, 4-bit phase counters, a two-stage ready synchronizer and the half-rate clock variant present. With these values both output-clock modes and both alignment outcomes can be reached. So can the zero-length clamp, the three-cycle active minimum under ready, and a ready rise late enough to stretch the active phase by several cycles. Every reached case is checked against lengths computed from the programmed values and the ready rise cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ALIGN  = 3'd1,
      ST_LEAD   = 3'd2,
      ST_ACTIVE = 3'd3,
      ST_TRAIL  = 3'd4
   } xbus_state_e;

endpackage

// File: rtl/xbus_busclk.sv
module xbus_busclk #(
   parameter bit HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_mode,
   output logic bus_clk_o,
   output logic phase_hi_o
);

   generate
      if (HALF_EN) begin : g_half
         logic ph_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= 1'b0;
            else        ph_q <= ~ph_q;
         end

         assign bus_clk_o  = half_mode ? ph_q : clk;
         assign phase_hi_o = ph_q;

         // divided clock alternates every timing cycle once running
         p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (ph_q != $past(ph_q)));
      end else begin : g_full
         assign bus_clk_o  = clk;
         assign phase_hi_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("xbus_rdy_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_wr_fsm.sv
module xbus_wr_fsm
   import xbus_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int MIN_ACT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_mode,
   input  logic             phase_hi,
   input  logic [CNT_W-1:0] cfg_lead,
   input  logic [CNT_W-1:0] cfg_active,
   input  logic [CNT_W-1:0] cfg_trail,
   input  logic             use_rdy,
   input  logic             rdy_sync,
   input  logic             req,
   output xbus_state_e      state_o,
   output logic             accept_o,
   output logic             lead_go_o,
   output logic             ack_o
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] MINA = CNT_W'(MIN_ACT);

   generate
      if (MIN_ACT >= (1 << CNT_W)) begin : g_bad_min
         $error("xbus_wr_fsm: MIN_ACT does not fit CNT_W");
      end
   endgenerate

   xbus_state_e      st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] lead_eff, act_eff, trail_eff;
   logic             need_align;
   logic             last_cyc;

   // clamp programmed lengths: zero means one, ready mode needs a floor
   always_comb begin
      lead_eff  = (cfg_lead  == ZERO) ? ONE : cfg_lead;
      trail_eff = (cfg_trail == ZERO) ? ONE : cfg_trail;
      act_eff   = (cfg_active == ZERO) ? ONE : cfg_active;
      if (use_rdy && (act_eff < MINA)) act_eff = MINA;
   end

   // divided clock high now means low next cycle: lead would start off-edge
   assign need_align = half_mode & phase_hi;
   assign last_cyc   = (cnt_q == ZERO);

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      accept_o  = 1'b0;
      lead_go_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req) begin
               accept_o = 1'b1;
               if (need_align) begin
                  st_d = ST_ALIGN;
               end else begin
                  st_d      = ST_LEAD;
                  cnt_d     = lead_eff - ONE;
                  lead_go_o = 1'b1;
               end
            end
         end
         ST_ALIGN: begin
            st_d      = ST_LEAD;
            cnt_d     = lead_eff - ONE;
            lead_go_o = 1'b1;
         end
         ST_LEAD: begin
            if (last_cyc) begin
               st_d  = ST_ACTIVE;
               cnt_d = act_eff - ONE;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
         ST_ACTIVE: begin
            if (!last_cyc) begin
               cnt_d = cnt_q - ONE;
            end else if (!use_rdy || rdy_sync) begin
               st_d  = ST_TRAIL;
               cnt_d = trail_eff - ONE;
            end
         end
         ST_TRAIL: begin
            if (last_cyc) st_d = ST_IDLE;
            else          cnt_d = cnt_q - ONE;
         end
         default: begin
            st_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= ZERO;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
   assign ack_o   = (st_q == ST_TRAIL) && last_cyc;

   // lead must open on a high divided clock in half-rate mode
   p_lead_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_mode && st_q == ST_LEAD && $past(st_q) != ST_LEAD) |-> phase_hi);

   // completion pulse lasts exactly one cycle
   p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   // alignment is a single cycle followed by lead
   p_align_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ALIGN) |=> (st_q == ST_LEAD));

   // ready mode never ends active before the floor length
   p_active_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (use_rdy && st_q == ST_ACTIVE && $past(st_q) == ST_LEAD) |-> (cnt_q >= MINA - ONE));

endmodule

// File: rtl/xbus_wr_seq.sv
module xbus_wr_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit HALF_CLK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_half_clk,
   input  logic [CNT_W-1:0]  cfg_lead,
   input  logic [CNT_W-1:0]  cfg_active,
   input  logic [CNT_W-1:0]  cfg_trail,
   input  logic              cfg_use_rdy,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              ack,
   input  logic              bus_rdy_async,
   output logic              bus_clk_out,
   output logic              bus_cs_n,
   output logic              bus_we_n,
   output logic              bus_rnw,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe
);

   // synchronizer latency sets where the first ready sample lands
   localparam int MIN_ACT = SYNC_STAGES + 1;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("xbus_wr_seq: bus widths must be positive");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("xbus_wr_seq: CNT_W must be at least 2");
      end
   endgenerate

   logic              phase_hi;
   logic              half_mode;
   logic              rdy_sync;
   logic              accept;
   logic              lead_go;
   xbus_state_e       state;
   logic [ADDR_W-1:0] pend_addr_q, addr_q;
   logic [DATA_W-1:0] pend_data_q, data_q;

   assign half_mode = HALF_CLK_EN & cfg_half_clk;

   xbus_busclk #(.HALF_EN(HALF_CLK_EN)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_mode  (half_mode),
      .bus_clk_o  (bus_clk_out),
      .phase_hi_o (phase_hi)
   );

   xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (bus_rdy_async),
      .sync_o  (rdy_sync)
   );

   xbus_wr_fsm #(.CNT_W(CNT_W), .MIN_ACT(MIN_ACT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_mode  (half_mode),
      .phase_hi   (phase_hi),
      .cfg_lead   (cfg_lead),
      .cfg_active (cfg_active),
      .cfg_trail  (cfg_trail),
      .use_rdy    (cfg_use_rdy),
      .rdy_sync   (rdy_sync),
      .req        (req),
      .state_o    (state),
      .accept_o   (accept),
      .lead_go_o  (lead_go),
      .ack_o      (ack)
   );

   // request capture at acceptance, bus copy at lead entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_addr_q <= '0;
         pend_data_q <= '0;
      end else if (accept) begin
         pend_addr_q <= req_addr;
         pend_data_q <= req_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (lead_go) begin
         addr_q <= accept ? req_addr : pend_addr_q;
         data_q <= accept ? req_data : pend_data_q;
      end
   end

   // strobes decoded from the registered phase
   always_comb begin
      bus_cs_n = 1'b1;
      bus_we_n = 1'b1;
      bus_rnw  = 1'b1;
      bus_doe  = 1'b0;
      unique case (state)
         ST_LEAD: begin
            bus_cs_n = 1'b0;
            bus_rnw  = 1'b0;
         end
         ST_ACTIVE: begin
            bus_cs_n = 1'b0;
            bus_we_n = 1'b0;
            bus_rnw  = 1'b0;
            bus_doe  = 1'b1;
         end
         ST_TRAIL: begin
            bus_rnw  = 1'b0;
            bus_doe  = 1'b1;
         end
         default: begin
         end
      endcase
   end

   assign bus_addr = addr_q;
   assign bus_dout = data_q;

   // write strobe only inside chip select
   p_we_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> !bus_cs_n);

   // data drivers only during a write cycle
   p_doe_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> !bus_rnw);

   // idle and alignment cycles keep strobes and drivers inactive
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n && bus_rnw) |-> (bus_we_n && !bus_doe));

   // address held across consecutive non-write cycles
   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rnw && $past(bus_rnw)) |-> $stable(bus_addr));

endmodule

// File: tb/tb_xbus_wr_seq.sv
`timescale 1ns/1ps
module tb_xbus_wr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_half_clk = 1'b0;
   logic [3:0]  cfg_lead = 4'd1, cfg_active = 4'd1, cfg_trail = 4'd1;
   logic        cfg_use_rdy = 1'b0;
   logic        req = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic        ack;
   logic        bus_rdy_async = 1'b1;
   logic        bus_clk_out, bus_cs_n, bus_we_n, bus_rnw, bus_doe;
   logic [18:0] bus_addr;
   logic [15:0] bus_dout;

   int checks = 0;
   int errs   = 0;
   int cyc    = 0;
   logic [18:0] last_addr = '0;

   always #2 clk = ~clk;

   xbus_wr_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_half_clk(cfg_half_clk),
      .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
      .cfg_use_rdy(cfg_use_rdy), .req(req), .req_addr(req_addr),
      .req_data(req_data), .ack(ack), .bus_rdy_async(bus_rdy_async),
      .bus_clk_out(bus_clk_out), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
      .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   // one write; caller stands at a negedge. rdy_at < 0: ready untouched
   task automatic run_write(input logic [18:0] a, input logic [15:0] d,
                            input int e_lead, input int e_act, input int e_trail,
                            input int rdy_at, input string rq);
      int exp_align, n_pre, n_lead, n_act, n_trl, n_ack, lead_clk;
      bit sig_ok, addr_ok;
      exp_align = cfg_half_clk ? int'(bus_clk_out) : 0;
      req = 1'b1; req_addr = a; req_data = d;
      n_pre = 0; n_lead = 0; n_act = 0; n_trl = 0; n_ack = 0; lead_clk = -1;
      sig_ok = 1'b1; addr_ok = 1'b1;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (n_lead == 0 && bus_cs_n && bus_rnw) begin
            n_pre++;
            if (!bus_we_n || bus_doe) sig_ok = 1'b0;
            if (bus_addr != last_addr) addr_ok = 1'b0;
         end else if (!bus_cs_n && bus_we_n) begin
            if (n_lead == 0) lead_clk = int'(bus_clk_out);
            n_lead++;
            if (bus_addr != a || bus_rnw || bus_doe) sig_ok = 1'b0;
         end else if (!bus_we_n) begin
            n_act++;
            if (bus_cs_n || bus_rnw || !bus_doe || bus_dout != d) sig_ok = 1'b0;
            if (rdy_at >= 0 && n_act == rdy_at + 1) bus_rdy_async = 1'b1;
         end else if (!bus_rnw) begin
            n_trl++;
            if (!bus_doe || bus_dout != d || bus_addr != a) sig_ok = 1'b0;
         end
         if (ack) begin
            n_ack++;
            req = 1'b0;
            break;
         end
      end
      chk(n_pre == exp_align, "R3", {rq, " alignment cycles"}, n_pre, exp_align);
      chk(n_lead == e_lead, "R1", {rq, " lead cycles"}, n_lead, e_lead);
      chk(n_act == e_act, rq, "active cycles", n_act, e_act);
      chk(n_trl == e_trail, "R1", {rq, " trail cycles"}, n_trl, e_trail);
      chk(sig_ok, "R6", {rq, " phase signal levels"}, int'(sig_ok), 1);
      chk(addr_ok, "R5", {rq, " address held before lead"}, int'(addr_ok), 1);
      chk(n_ack == 1, "R1", {rq, " ack in last trail cycle"}, n_ack, 1);
      if (cfg_half_clk)
         chk(lead_clk == 1, "R3", {rq, " bus clock high at lead start"}, lead_clk, 1);
      @(negedge clk);
      chk(!ack, "R9", {rq, " ack single cycle"}, int'(ack), 0);
      chk(bus_cs_n && bus_we_n && bus_rnw && !bus_doe, "R4", {rq, " idle levels"},
          int'({bus_cs_n, bus_we_n, bus_rnw, bus_doe}), 14);
      chk(bus_addr == a, "R5", {rq, " address held in idle"}, int'(bus_addr), int'(a));
      repeat (3) @(negedge clk);
      chk(bus_cs_n && bus_addr == a && !ack, "R9", {rq, " no second cycle"},
          int'(bus_cs_n), 1);
      last_addr = a;
   endtask

   task automatic wait_phase(input logic v);
      @(negedge clk);
      while (bus_clk_out != v) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(bus_cs_n && bus_we_n && bus_rnw, "R4", "reset strobes",
          int'({bus_cs_n, bus_we_n, bus_rnw}), 7);
      chk(!bus_doe && !ack, "R4", "reset drivers and ack", int'({bus_doe, ack}), 0);
   endtask

   task automatic t_basic();
      cfg_half_clk = 0; cfg_use_rdy = 0;
      cfg_lead = 4'd2; cfg_active = 4'd4; cfg_trail = 4'd3;
      run_write(19'h12345, 16'hA5C3, 2, 4, 3, -1, "R1");
      cfg_lead = 4'd5; cfg_active = 4'd2; cfg_trail = 4'd1;
      run_write(19'h7FFFF, 16'h0F0F, 5, 2, 1, -1, "R1");
   endtask

   task automatic t_zero_len();
      cfg_lead = 4'd0; cfg_active = 4'd0; cfg_trail = 4'd0;
      run_write(19'h00AB1, 16'h1234, 1, 1, 1, -1, "R2");
   endtask

   task automatic t_half();
      logic prev;
      cfg_half_clk = 1; cfg_lead = 4'd1; cfg_active = 4'd2; cfg_trail = 4'd2;
      @(negedge clk);
      prev = bus_clk_out;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(bus_clk_out != prev, "R3", "half-rate bus clock toggles",
             int'(bus_clk_out), int'(!prev));
         prev = bus_clk_out;
      end
      wait_phase(1'b1);
      run_write(19'h05555, 16'hBEEF, 1, 2, 2, -1, "R3");
      wait_phase(1'b0);
      cfg_lead = 4'd2;
      run_write(19'h2AAAA, 16'hCAFE, 2, 2, 2, -1, "R3");
      cfg_half_clk = 0;
      @(negedge clk);
   endtask

   task automatic t_ready();
      cfg_use_rdy = 1; cfg_lead = 4'd1; cfg_active = 4'd3; cfg_trail = 4'd1;
      bus_rdy_async = 1'b1;
      run_write(19'h01111, 16'h1111, 1, 3, 1, -1, "R7");
      bus_rdy_async = 1'b0;
      run_write(19'h02222, 16'h2222, 1, 7, 1, 4, "R7");
      bus_rdy_async = 1'b0;
      run_write(19'h03333, 16'h3333, 1, 5, 1, 2, "R7");
      cfg_active = 4'd1; bus_rdy_async = 1'b1;
      repeat (3) @(negedge clk);
      run_write(19'h04444, 16'h4444, 1, 3, 1, -1, "R7");
   endtask

   task automatic t_ready_off();
      cfg_use_rdy = 0; cfg_active = 4'd2; bus_rdy_async = 1'b0;
      repeat (3) @(negedge clk);
      run_write(19'h06666, 16'h6666, 1, 2, 1, -1, "R8");
      bus_rdy_async = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_zero_len();
      t_half();
      t_ready();
      t_ready_off();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule